// File: doc/BRIEF.md
# Random Word Software Readout Port

This block is the path through which software reaches freshly generated random data. An upstream generator offers wide blocks (128 bits by default) on a valid/ready handshake, each with a flag that marks it compliant. Software reads the block through a 32-bit window, one word per read strobe. The block takes the next block only after the last word of the current one has been read.

All reads pass through a two-key gate. One key is a 4-bit software control field. The other is an 8-bit enable vector that a one-time-programmable fuse block provides. Unless both keys hold their exact enable encodings, reads return zero, the status bits read as zero and the word pointer stays where it is. The block also compares each block it consumes with the block it consumed before. If the two are equal, it raises a sticky alert that only a software write of zero clears.

Top module: `rng_word_readout`

## Requirements
- R1: The gate is open only when `sw_en` equals 4'h6 and `otp_en` equals 8'h96. Any other value on either input, including the false encoding 4'h9, closes it. While the gate is closed, `rd_data` is zero.
- R2: Words come out least-significant first. With the gate open and a block valid, the k-th accepted read of that block (k = 0..3) returns `blk_data[32k+31:32k]`, shown combinationally on `rd_data` in the cycle of the read.
- R3: A block takes exactly four accepted reads. `blk_ready` goes high only in the cycle of the fourth accepted read, so the block is consumed in that cycle and the next read starts again at word 0.
- R4: A read strobe while the gate is closed is ignored. It returns zero and does not advance the word pointer, so the next accepted read returns the same word that the ignored read would have returned.
- R5: `stat_valid` is high when the gate is open and `blk_valid` is high. `stat_compliant` is high when `stat_valid` is high and `blk_compliant` is high. Both are zero when the gate is closed.
- R6: A read strobe with no valid block returns zero and does not advance the word pointer.
- R7: The block keeps a 128-bit reference register, cleared to zero at reset and loaded with each consumed block. If a consumed block equals the reference, `repeat_alert` is high from the next cycle on. As a result, an all-zero first block after reset also raises the alert.
- R8: `repeat_alert` is sticky. A cycle with `alert_wr` high and `alert_wdata` low clears it. A write with `alert_wdata` high has no effect. A new repeat in the same cycle as a clear wins, and the alert stays set.
- R9: After reset, `repeat_alert` is low and the word pointer is at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_valid | input | 1 | Generated block offered |
| blk_ready | output | 1 | Block consumed this cycle |
| blk_data | input | BLK_W | Generated block |
| blk_compliant | input | 1 | Compliance flag of the offered block |
| sw_en | input | 4 | Software read-enable field (true 4'h6, false 4'h9) |
| otp_en | input | 8 | Fuse enable vector (enable 8'h96) |
| rd_req | input | 1 | Software read strobe on the data window |
| rd_data | output | WORD_W | Read data |
| stat_valid | output | 1 | Status bit 0: data available |
| stat_compliant | output | 1 | Status bit 1: current data compliant |
| repeat_alert | output | 1 | Sticky repeated-block alert |
| alert_wr | input | 1 | Software write strobe to the alert bit |
| alert_wdata | input | 1 | Value written to the alert bit (0 clears) |

## Verification
The bench builds the block with its default parameters: 128-bit blocks split into four 32-bit words. With only four words per block, the random read stream quickly covers every word position and many block turnovers. In about one block in eight, the bench offers a copy of the previously consumed block, so the repeat alert is set and cleared many times. This includes clears that arrive in the same cycle as a new repeat. Because the pointer is only two bits wide, a gate left closed in the middle of a block is easy to provoke, and the bench checks that reads resume on the correct word.

// File: rtl/rng_word_readout.sv
module rng_word_readout #(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_valid,
  output logic              blk_ready,
  input  logic [BLK_W-1:0]  blk_data,
  input  logic              blk_compliant,
  input  logic [3:0]        sw_en,
  input  logic [7:0]        otp_en,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_data,
  output logic              stat_valid,
  output logic              stat_compliant,
  output logic              repeat_alert,
  input  logic              alert_wr,
  input  logic              alert_wdata
);
  localparam int NWORDS = BLK_W / WORD_W;
  localparam int PTR_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NWORDS - 1);
  localparam logic [3:0] SW_TRUE = 4'h6;
  localparam logic [7:0] OTP_ON  = 8'h96;

  logic [PTR_W-1:0] ptr_q;
  logic [BLK_W-1:0] last_q;
  logic             gate, live, rd_acc, pop, rpt_set, rpt_clr;

  assign gate    = (sw_en == SW_TRUE) && (otp_en == OTP_ON);
  assign live    = gate && blk_valid;
  assign rd_acc  = rd_req && live;
  assign blk_ready = rd_acc && (ptr_q == LAST);
  assign pop     = blk_valid && blk_ready;
  assign rpt_set = pop && (blk_data == last_q);
  assign rpt_clr = alert_wr && !alert_wdata;

  assign rd_data        = live ? blk_data[int'(ptr_q)*WORD_W +: WORD_W] : '0;
  assign stat_valid     = live;
  assign stat_compliant = live && blk_compliant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      last_q       <= '0;
      repeat_alert <= 1'b0;
    end else begin
      if (rd_acc) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (pop) last_q <= blk_data;
      if (rpt_set) repeat_alert <= 1'b1;
      else if (rpt_clr) repeat_alert <= 1'b0;
    end
  end

  // R1
  p_gate_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> rd_data == '0);
  // R4
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !gate) |=> $stable(ptr_q));
  // R3
  p_pop_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> ptr_q == '0);
  // R7
  p_repeat_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_set |=> repeat_alert);
  // R8
  p_alert_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_alert && !rpt_clr) |=> repeat_alert);
  // R5
  p_status_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_compliant |-> stat_valid);
endmodule

// File: tb/rng_word_readout_test.sv
module rng_word_readout_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         blk_valid = 0;
  logic         blk_ready;
  logic [127:0] blk_data = '0;
  logic         blk_compliant = 0;
  logic [3:0]   sw_en = 4'h9;
  logic [7:0]   otp_en = 8'h00;
  logic         rd_req = 0;
  logic [31:0]  rd_data;
  logic         stat_valid, stat_compliant, repeat_alert;
  logic         alert_wr = 0, alert_wdata = 0;

  int n_chk = 0, n_fail = 0;
  int ptr_m = 0;
  logic [127:0] last_m = '0;
  logic alert_m = 0;
  logic [127:0] prev_pop = '0;

  rng_word_readout uut (.*);

  always #2 clk = ~clk;

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd_blk();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // One cycle: check alert, drive inputs, check comb outputs, update model.
  task automatic cyc(logic rd, logic [3:0] sw, logic [7:0] ot, logic aw, logic ad);
    logic g, live, acc, pop;
    @(negedge clk);
    chk("R8 alert", repeat_alert, alert_m);
    rd_req = rd; sw_en = sw; otp_en = ot; alert_wr = aw; alert_wdata = ad;
    #1;
    g    = (sw == 4'h6) && (ot == 8'h96);
    live = g && blk_valid;
    acc  = rd && live;
    pop  = acc && (ptr_m == 3);
    if (!g) chk("R1 gated data", rd_data, 0);
    else if (!blk_valid) chk("R6 no-valid data", rd_data, 0);
    else chk("R2 word", rd_data, blk_data[ptr_m*32 +: 32]);
    chk("R3 ready", blk_ready, pop);
    chk("R5 valid", stat_valid, live);
    chk("R5 compliant", stat_compliant, live && blk_compliant);
    if (pop) begin
      if (blk_data == last_m) alert_m = 1;
      else if (aw && !ad) alert_m = 0;
      last_m = blk_data;
    end else if (aw && !ad) alert_m = 0;
    if (acc) ptr_m = (ptr_m == 3) ? 0 : ptr_m + 1;
    @(posedge clk);
    #1;
    if (pop) begin
      prev_pop = blk_data;
      blk_valid = ($urandom_range(0, 5) != 0);
      blk_data = ($urandom_range(0, 7) == 0) ? prev_pop : rnd_blk();
      blk_compliant = $urandom_range(0, 1);
    end else if (!blk_valid && $urandom_range(0, 2) == 0) begin
      blk_valid = 1;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 alert reset", repeat_alert, 0);
    rst_n = 1;
    // R9/R7: first block all zero matches cleared reference
    blk_valid = 1; blk_data = '0; blk_compliant = 1;
    for (int i = 0; i < 4; i++) cyc(1, 4'h6, 8'h96, 0, 0);
    // R8: write of one keeps alert
    cyc(0, 4'h6, 8'h96, 1, 1);
    cyc(0, 4'h6, 8'h96, 1, 0);
    // R4: closed gate mid-block, false encoding and bad fuse
    blk_data = 128'h44444444_33333333_22222222_11111111;
    cyc(1, 4'h6, 8'h96, 0, 0);
    cyc(1, 4'h9, 8'h96, 0, 0);
    cyc(1, 4'h6, 8'h69, 0, 0);
    cyc(1, 4'h6, 8'h96, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] sw; logic [7:0] ot; int r;
      sw = 4'h6; ot = 8'h96;
      r = $urandom_range(0, 9);
      if (r == 0) sw = 4'h9;
      else if (r == 1) sw = 4'($urandom);
      else if (r == 2) ot = 8'($urandom);
      cyc($urandom_range(0, 3) != 0, sw, ot,
          $urandom_range(0, 9) == 0, $urandom_range(0, 1));
    end
    @(negedge clk);
    chk("R8 final alert", repeat_alert, alert_m);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule